// File: doc/BRIEF.md
# Media Integer Element ALU

This block is a single-element integer unit for audio and video kernels. It computes one of four primitives on a pair of operands: rounding average, absolute difference, minimum or maximum. A signedness flag picks the ordering and the extension rule. A width select picks an element size of 8, 16 or 32 bits. The result is truncated to the selected element size and placed in the low bits of a 32-bit result word, and every bit above the element is cleared.

The data path is combinational and ends in one output register. A request is presented together with `in_valid`. The result and `out_valid` appear one clock later. A surrounding sequencer that walks a vector issues one element per cycle. Packing and lane selection stay in that sequencer.

Top module: `media_elem_alu`

## Requirements
- R1: With `op` = 2'b00 and `is_signed` = 0, the result is (a + b + 1) >> 1 on the zero-extended element values, computed with no loss of the carry, so two all-ones operands give all ones at the element width.
- R2: With `op` = 2'b00 and `is_signed` = 1, the element values are sign-extended and the sum a + b + 1 is shifted right arithmetically, which rounds the half toward plus infinity (for example, -128 and -1 at 8 bits give 0xC0).
- R3: With `op` = 2'b01, the result is a − b when a > b and b − a otherwise, truncated to the element width; the comparison follows `is_signed`.
- R4: With `op` = 2'b10 the result is a when a < b and b otherwise. With `op` = 2'b11 it is a when a > b and b otherwise. Ordering is two's-complement when `is_signed` = 1 and unsigned when it is 0.
- R5: `width_sel` 2'b00, 2'b01 and 2'b10 select 8, 16 and 32-bit elements, and 2'b11 is treated as 32. Only the low element bits of each operand take part in the operation.
- R6: Result bits above the selected element width are zero.
- R7: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R8: `result` is loaded only on a clock edge with `in_valid` high, and holds its value otherwise.
- R9: While `rst_n` is low at a clock edge, `out_valid` and `result` become zero, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | Operation: 00 average, 01 absolute difference, 10 minimum, 11 maximum |
| is_signed | input | 1 | 1 = two's-complement elements, 0 = unsigned |
| width_sel | input | 2 | Element size: 00 = 8, 01 = 16, 10 or 11 = 32 |
| src_a | input | 32 | First operand, element in the low bits |
| src_b | input | 32 | Second operand, element in the low bits |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 32 | Registered, zero-extended element result |

## Verification
The bench averages two all-ones operands. A design that drops the carry before the shift returns a halved value there. The bench also sets the sign bit at 8 and 16 bits in both signedness modes. A design that ignores `is_signed` makes min and max pick the wrong operand. A design that shifts the signed sum logically is off by a large power of two at narrow widths.

The bench places junk in the operand bits above the element. A design that does not isolate the element lets those bits leak into the ordering or into the upper result bits.

Finally, the bench checks the hold behaviour, the reserved width code and a request that arrives during reset. These expose a result register that loads on every edge, a missing default width, and a reset that does not win over `in_valid`.

// File: rtl/mea_pkg.sv
// Shared encodings for the media element ALU.
// Assumes three element sizes, each half of the next, with the largest equal to the data width.
package mea_pkg;

    localparam int NUM_W = 3;

    typedef enum logic [1:0] {
        OP_AVG  = 2'b00,
        OP_ABSD = 2'b01,
        OP_MIN  = 2'b10,
        OP_MAX  = 2'b11
    } mea_op_e;

    typedef enum logic [1:0] {
        EW_8   = 2'b00,
        EW_16  = 2'b01,
        EW_32  = 2'b10,
        EW_RSV = 2'b11
    } mea_width_e;

    // Map a width code to an element-size index; the reserved code selects the widest size.
    function automatic logic [1:0] width_index(input logic [1:0] ws);
        return (ws == EW_RSV) ? 2'(NUM_W - 1) : ws;
    endfunction

endpackage

// File: rtl/mea_operand_ext.sv
// Isolates the selected element of one operand and extends it by one bit.
// Assumes DATA_W is divisible by 4. Output is a two's-complement value one bit wider
// than the data, so unsigned 32-bit elements stay positive.
module mea_operand_ext
    import mea_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int EXT_W = DATA_W + 1
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        width_sel,
    input  logic              is_signed,
    output logic [EXT_W-1:0]  ext
);

    logic [EXT_W-1:0] cand [NUM_W];

    for (genvar g = 0; g < NUM_W; g++) begin : g_size
        localparam int LW = DATA_W >> (NUM_W - 1 - g);
        // Extend the low LW bits by sign or by zero
        always_comb begin
            cand[g] = {{(EXT_W - LW){is_signed & raw[LW-1]}}, raw[LW-1:0]};
        end
    end

    // Pick the candidate for the requested element size
    always_comb begin
        ext = cand[width_index(width_sel)];
    end

endmodule

// File: rtl/mea_core.sv
// Combinational arithmetic for the four element primitives.
// Assumes both inputs are already extended to DATA_W+1 bits two's-complement.
// Output holds the low DATA_W bits of the chosen result, before width trimming.
module mea_core
    import mea_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int EXT_W = DATA_W + 1
) (
    input  logic [EXT_W-1:0]  a_ext,
    input  logic [EXT_W-1:0]  b_ext,
    input  logic [1:0]        op,
    output logic [DATA_W-1:0] res
);

    logic signed [EXT_W:0] sum;
    logic                  a_gt_b;
    logic                  a_lt_b;
    mea_op_e               op_e;

    // Rounding sum with one guard bit above the extended operands
    always_comb begin
        sum = $signed({a_ext[EXT_W-1], a_ext}) + $signed({b_ext[EXT_W-1], b_ext})
              + $signed((EXT_W + 1)'(1));
    end

    // Shared ordering on the extended values
    always_comb begin
        a_gt_b = $signed(a_ext) > $signed(b_ext);
        a_lt_b = $signed(a_ext) < $signed(b_ext);
    end

    // Select the primitive named by the opcode
    always_comb begin
        op_e = mea_op_e'(op);
        case (op_e)
            OP_AVG:  res = DATA_W'(sum >>> 1);
            OP_ABSD: res = DATA_W'(a_gt_b ? (a_ext - b_ext) : (b_ext - a_ext));
            OP_MIN:  res = DATA_W'(a_lt_b ? a_ext : b_ext);
            OP_MAX:  res = DATA_W'(a_gt_b ? a_ext : b_ext);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mea_result_trim.sv
// Clears the result bits above the selected element size.
// Assumes the same width coding as the operand extender.
module mea_result_trim
    import mea_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value,
    input  logic [1:0]        width_sel,
    output logic [DATA_W-1:0] trimmed
);

    logic [DATA_W-1:0] mask [NUM_W];

    for (genvar g = 0; g < NUM_W; g++) begin : g_mask
        localparam int LW = DATA_W >> (NUM_W - 1 - g);
        // Low-LW-bits mask for this element size
        always_comb begin
            mask[g] = {DATA_W{1'b1}} >> (DATA_W - LW);
        end
    end

    // Apply the mask of the requested element size
    always_comb begin
        trimmed = value & mask[width_index(width_sel)];
    end

endmodule

// File: rtl/media_elem_alu.sv
// Media integer element ALU: rounding average, absolute difference, min and max
// on one element of 8, 16 or 32 bits, signed or unsigned, with a registered output.
// Assumes a single clock and a synchronous active-low reset. One request per cycle.
module media_elem_alu #(
    parameter int DATA_W = 32,
    localparam int EXT_W = DATA_W + 1,
    localparam int MIN_W = DATA_W / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic              is_signed,
    input  logic [1:0]        width_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    logic [EXT_W-1:0]  a_ext;
    logic [EXT_W-1:0]  b_ext;
    logic [DATA_W-1:0] core_res;
    logic [DATA_W-1:0] next_res;

    mea_operand_ext #(.DATA_W(DATA_W)) u_ext_a (
        .raw(src_a), .width_sel(width_sel), .is_signed(is_signed), .ext(a_ext)
    );

    mea_operand_ext #(.DATA_W(DATA_W)) u_ext_b (
        .raw(src_b), .width_sel(width_sel), .is_signed(is_signed), .ext(b_ext)
    );

    mea_core #(.DATA_W(DATA_W)) u_core (
        .a_ext(a_ext), .b_ext(b_ext), .op(op), .res(core_res)
    );

    mea_result_trim #(.DATA_W(DATA_W)) u_trim (
        .value(core_res), .width_sel(width_sel), .trimmed(next_res)
    );

    // Output register: valid follows the request, data loads only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end

    // Checks on the output register
    p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && width_sel == 2'b00) |=> (result[DATA_W-1:MIN_W] == '0));

    p_absd_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01 && src_a == src_b) |=> (result == '0));

    p_avg_same_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && width_sel == 2'b10 && src_a == src_b)
        |=> (result == $past(src_a)));

    p_minmax_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1] && width_sel == 2'b10)
        |=> (result == $past(src_a) || result == $past(src_b)));

endmodule

// File: tb/media_elem_alu_bench.sv
`timescale 1ns/1ps
module media_elem_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  op;
    logic        is_signed;
    logic [1:0]  width_sel;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    media_elem_alu u_media_elem_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .is_signed(is_signed), .width_sel(width_sel), .src_a(src_a),
        .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        sg;
        logic [1:0]  ws;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VT [NV] = '{
        '{2'd0, 1'b0, 2'd0, 32'hAAAAAA03, 32'h55555504, 32'h00000004},
        '{2'd0, 1'b0, 2'd0, 32'h000000FF, 32'h000000FF, 32'h000000FF},
        '{2'd0, 1'b0, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
        '{2'd0, 1'b0, 2'd1, 32'h0000FFFF, 32'h00000000, 32'h00008000},
        '{2'd0, 1'b1, 2'd0, 32'h00000080, 32'h000000FF, 32'h000000C0},
        '{2'd0, 1'b1, 2'd0, 32'h0000007F, 32'h0000007F, 32'h0000007F},
        '{2'd0, 1'b1, 2'd1, 32'h00008000, 32'h00008001, 32'h00008001},
        '{2'd0, 1'b1, 2'd2, 32'hFFFFFFFD, 32'h00000000, 32'hFFFFFFFF},
        '{2'd1, 1'b0, 2'd0, 32'h00000010, 32'h000000F0, 32'h000000E0},
        '{2'd1, 1'b0, 2'd0, 32'h000000F0, 32'h00000010, 32'h000000E0},
        '{2'd1, 1'b0, 2'd2, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF},
        '{2'd1, 1'b0, 2'd1, 32'h12340005, 32'hABCD0009, 32'h00000004},
        '{2'd1, 1'b1, 2'd0, 32'h00000080, 32'h0000007F, 32'h000000FF},
        '{2'd2, 1'b0, 2'd0, 32'h00000080, 32'h0000007F, 32'h0000007F},
        '{2'd2, 1'b1, 2'd0, 32'h00000080, 32'h0000007F, 32'h00000080},
        '{2'd3, 1'b0, 2'd0, 32'h00000080, 32'h0000007F, 32'h00000080},
        '{2'd3, 1'b1, 2'd0, 32'h00000080, 32'h0000007F, 32'h0000007F},
        '{2'd3, 1'b1, 2'd1, 32'h0000FFFF, 32'h00000001, 32'h00000001},
        '{2'd3, 1'b0, 2'd1, 32'h0000FFFF, 32'h00000001, 32'h0000FFFF},
        '{2'd2, 1'b1, 2'd2, 32'h80000000, 32'h7FFFFFFF, 32'h80000000},
        '{2'd3, 1'b0, 2'd2, 32'h80000000, 32'h7FFFFFFF, 32'h80000000},
        '{2'd2, 1'b1, 2'd1, 32'hFFFF0003, 32'h00008000, 32'h00008000},
        '{2'd0, 1'b0, 2'd3, 32'h10000002, 32'h10000004, 32'h10000003}
    };

    function automatic string tag_of(input logic [1:0] o, input logic s);
        if (o == 2'd0) return s ? "R2" : "R1";
        if (o == 2'd1) return "R3";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Present one request at a falling edge; sample the outputs one falling edge later
    task automatic issue(input logic [1:0] o, input logic s, input logic [1:0] w,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic v);
        @(negedge clk);
        op = o; is_signed = s; width_sel = w; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        r = result;
        v = out_valid;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        v;
        logic [31:0] held;

        // R9: a request during reset must not reach the outputs
        rst_n = 1'b0; in_valid = 1'b1; op = 2'd3; is_signed = 1'b0;
        width_sel = 2'd2; src_a = 32'h12345678; src_b = 32'h0;
        repeat (3) @(negedge clk);
        check("R9 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check("R9 result in reset", result, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle out_valid", {31'b0, out_valid}, 32'h0);

        // Table walk over the primitives
        for (int i = 0; i < NV; i++) begin
            issue(VT[i].op, VT[i].sg, VT[i].ws, VT[i].a, VT[i].b, r, v);
            check($sformatf("%s row %0d", tag_of(VT[i].op, VT[i].sg), i), r, VT[i].e);
        end

        // R7: valid one cycle after the request, gone the cycle after it ends
        issue(2'd0, 1'b0, 2'd0, 32'h2, 32'h4, r, v);
        check("R7 out_valid after request", {31'b0, v}, 32'h1);
        @(negedge clk);
        check("R7 out_valid after idle", {31'b0, out_valid}, 32'h0);

        // R8: data held while no request, despite changing operands
        held = result;
        op = 2'd3; is_signed = 1'b0; width_sel = 2'd2;
        src_a = 32'hDEADBEEF; src_b = 32'h1;
        repeat (2) @(negedge clk);
        check("R8 hold", result, held);
        check("R8 hold value", held, 32'h00000003);

        // R5: upper junk ignored at 8 bits
        issue(2'd0, 1'b0, 2'd0, 32'hFFFFFF02, 32'h00FFFF02, r, v);
        check("R5 narrow operand isolation", r, 32'h00000002);
        // R5: junk above 16 bits does not alter signed ordering
        issue(2'd3, 1'b1, 2'd1, 32'h7FFF8000, 32'h80000001, r, v);
        check("R5 narrow signed order", r, 32'h00000001);

        // R6: upper bits cleared even when the element is all ones
        issue(2'd3, 1'b0, 2'd1, 32'hFFFFFFFF, 32'h00000000, r, v);
        check("R6 upper zero 16", r, 32'h0000FFFF);
        issue(2'd0, 1'b1, 2'd0, 32'hFFFFFF80, 32'hFFFFFF80, r, v);
        check("R6 upper zero signed 8", r, 32'h00000080);

        summary();
        $finish;
    end

endmodule